// File: doc/BRIEF.md
# Local Step Sequencer with Peer Handshakes

This block is one node of a static schedule that has been split across several processing elements. Each element, whether a programmable core or a fixed-function hardware subsystem, owns one copy of the block. The copy issues start pulses to the tasks mapped onto that element and collects their completion pulses. It exchanges single-cycle handshake tokens with the copies that serve the other elements only at the points where the static order needs it. Most ordering therefore stays local, and a whole schedule may need just one crossing between elements.

The order is held in a small program memory. Each entry has a 2-bit kind in bits [4:3] and a 3-bit index in bits [2:0]. There are four kinds: fire a local task, wait for a local task to finish, post a token to a peer, and wait for a token from a peer. Software writes entries while the block is idle. It then pulses `go` with the number of entries to run, and the block walks them once. Tokens that arrive from peers are counted per peer, so a token that comes early is consumed when the matching wait step is reached.

Top module: `dist_local_sequencer`

## Requirements
- R1: After reset, `busy`, `err`, `iter_done`, `stalled`, `pc`, `task_start` and `sync_out` are all zero.
- R2: A `go` pulse while idle captures `prog_len`, sets `pc` to 0 and raises `busy` on the next edge. A `go` while busy has no effect, and `pc` never exceeds the captured length.
- R3: A current entry of kind 00 drives `task_start[idx]` high for exactly that cycle, and `pc` advances on the next edge.
- R4: A current entry of kind 01 holds `pc` with `stalled` high until task `idx` has finished. A finish counts whether it comes in that cycle or at any time since the task was fired in this run. The wait consumes that finish.
- R5: A current entry of kind 10 drives `sync_out[idx mod N_PEERS]` high for that cycle, and `pc` advances on the next edge.
- R6: A current entry of kind 11 advances when peer `idx mod N_PEERS` has a nonzero token count or a token on `sync_in` in that same cycle, and consumes one token. Otherwise it stalls.
- R7: Each peer's token count is 4 bits wide and saturates at 15. Tokens beyond 15 are lost, so 16 waits on 17 stored arrivals stall at the 16th.
- R8: When `pc` equals the captured length while busy, `iter_done` is high for that cycle and `busy` falls on the next edge. A length of 0 completes at once.
- R9: `err` rises, and stays high until reset, when `task_done[i]` arrives for a task that has not been fired since the last accepted `go`.
- R10: Program writes through `ld_en` while busy are ignored, and the stored entry is unchanged in later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Program entry write strobe |
| ld_addr | input | 4 | Program entry address |
| ld_data | input | 5 | Entry: kind in [4:3], index in [2:0] |
| go | input | 1 | Begin one pass over the program |
| prog_len | input | 5 | Number of entries to run (0..16) |
| task_start | output | 8 | Fire pulse per local task |
| task_done | input | 8 | Finish pulse per local task |
| sync_out | output | 4 | Token pulse to each peer |
| sync_in | input | 4 | Token pulse from each peer |
| busy | output | 1 | A pass is in progress |
| iter_done | output | 1 | Pass completes this cycle |
| err | output | 1 | Sticky: finish from an unfired task |
| pc | output | 5 | Index of the current entry |
| stalled | output | 1 | Current wait step is blocked |

## Verification
The properties assume that every input is a single-cycle pulse sampled at the clock edge, and that a task never reports its finish in the cycle it is fired. The bench drives all inputs just after a rising edge and holds them for one full cycle. It pulses a finish only at least one cycle after the matching fire pulse, except in the deliberate error case. The behavioural model in the bench applies the same input rules, so the per-clock comparison never depends on how the design would treat out-of-range stimulus.

// File: rtl/lsched_pkg.sv
package lsched_pkg;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned ENTRY_W = 2 + IDX_W;

  typedef enum logic [1:0] {
    STEP_FIRE  = 2'd0,
    STEP_JOIN  = 2'd1,
    STEP_POST  = 2'd2,
    STEP_AWAIT = 2'd3
  } step_kind_e;

  function automatic step_kind_e entry_kind(input logic [ENTRY_W-1:0] e);
    return step_kind_e'(e[ENTRY_W-1 -: 2]);
  endfunction

  function automatic logic [IDX_W-1:0] entry_idx(input logic [ENTRY_W-1:0] e);
    return e[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/lsched_prog_store.sv
module lsched_prog_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 5,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lsched_task_track.sv
module lsched_task_track #(
  parameter int unsigned N_TASKS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [N_TASKS-1:0] fire,
  input  logic [N_TASKS-1:0] task_done,
  input  logic [N_TASKS-1:0] consume,
  output logic [N_TASKS-1:0] ready,
  output logic               bad_done
);
  logic [N_TASKS-1:0] bad;

  for (genvar i = 0; i < N_TASKS; i++) begin : g_task
    logic started_q, pend_q, done_ok;
    assign done_ok  = task_done[i] & started_q;
    assign ready[i] = pend_q | done_ok;
    assign bad[i]   = task_done[i] & ~started_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        started_q <= 1'b0;
        pend_q    <= 1'b0;
      end else if (clr) begin
        started_q <= 1'b0;
        pend_q    <= 1'b0;
      end else begin
        started_q <= started_q | fire[i];
        pend_q    <= (pend_q | done_ok) & ~consume[i];
      end
    end
  end

  assign bad_done = |bad;
endmodule

// File: rtl/lsched_sync_bank.sv
module lsched_sync_bank #(
  parameter int unsigned N_PEERS = 4,
  parameter int unsigned CNT_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PEERS-1:0]         sync_in,
  input  logic [N_PEERS-1:0]         consume,
  output logic [N_PEERS-1:0]         avail,
  output logic [N_PEERS*CNT_W-1:0]   cnt_all
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic inc, input logic dec);
    if (inc && !dec) return (c == CMAX) ? c : c + 1'b1;
    if (dec && !inc) return c - 1'b1;
    return c;
  endfunction

  for (genvar p = 0; p < N_PEERS; p++) begin : g_peer
    logic [CNT_W-1:0] cnt_q;
    assign avail[p] = (cnt_q != '0) | sync_in[p];
    assign cnt_all[p*CNT_W +: CNT_W] = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next(cnt_q, sync_in[p], consume[p]);
    end
  end
endmodule

// File: rtl/dist_local_sequencer.sv
module dist_local_sequencer
  import lsched_pkg::*;
#(
  parameter int unsigned N_TASKS = 8,
  parameter int unsigned N_PEERS = 4,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned CNT_W   = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned TW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1,
  localparam int unsigned PW = (N_PEERS > 1) ? $clog2(N_PEERS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [AW-1:0]      ld_addr,
  input  logic [ENTRY_W-1:0] ld_data,
  input  logic               go,
  input  logic [AW:0]        prog_len,
  output logic [N_TASKS-1:0] task_start,
  input  logic [N_TASKS-1:0] task_done,
  output logic [N_PEERS-1:0] sync_out,
  input  logic [N_PEERS-1:0] sync_in,
  output logic               busy,
  output logic               iter_done,
  output logic               err,
  output logic [AW:0]        pc,
  output logic               stalled
);
  logic                     busy_q, err_q;
  logic [AW:0]              pc_q, len_q;
  logic [ENTRY_W-1:0]       cur;
  step_kind_e               kind;
  logic [IDX_W-1:0]         ix;
  logic [TW-1:0]            tix;
  logic [PW-1:0]            pix;
  logic                     go_acc, at_end, exec, adv, bad_done;
  logic [N_TASKS-1:0]       fire, t_cons, t_ready;
  logic [N_PEERS-1:0]       post, s_cons, s_avail;
  logic [N_PEERS*CNT_W-1:0] cnt_all;

  assign go_acc = go & ~busy_q;
  assign at_end = busy_q & (pc_q == len_q);
  assign exec   = busy_q & ~at_end;
  assign kind   = entry_kind(cur);
  assign ix     = entry_idx(cur);
  assign tix    = ix[TW-1:0];
  assign pix    = ix[PW-1:0];

  lsched_prog_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
    .clk(clk), .we(ld_en & ~busy_q), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc_q[AW-1:0]), .rdata(cur)
  );

  lsched_task_track #(.N_TASKS(N_TASKS)) u_tasks (
    .clk(clk), .rst_n(rst_n), .clr(go_acc), .fire(fire), .task_done(task_done),
    .consume(t_cons), .ready(t_ready), .bad_done(bad_done)
  );

  lsched_sync_bank #(.N_PEERS(N_PEERS), .CNT_W(CNT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .consume(s_cons),
    .avail(s_avail), .cnt_all(cnt_all)
  );

  always_comb begin
    fire   = '0;
    post   = '0;
    t_cons = '0;
    s_cons = '0;
    adv    = 1'b0;
    if (exec) begin
      case (kind)
        STEP_FIRE: begin
          fire[tix] = 1'b1;
          adv       = 1'b1;
        end
        STEP_JOIN: if (t_ready[tix]) begin
          t_cons[tix] = 1'b1;
          adv         = 1'b1;
        end
        STEP_POST: begin
          post[pix] = 1'b1;
          adv       = 1'b1;
        end
        STEP_AWAIT: if (s_avail[pix]) begin
          s_cons[pix] = 1'b1;
          adv         = 1'b1;
        end
        default: adv = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_q | bad_done;
      if (go_acc) begin
        busy_q <= 1'b1;
        pc_q   <= '0;
        len_q  <= prog_len;
      end else if (at_end) begin
        busy_q <= 1'b0;
      end else if (adv) begin
        pc_q <= pc_q + (AW+1)'(1);
      end
    end
  end

  assign task_start = fire;
  assign sync_out   = post;
  assign busy       = busy_q;
  assign iter_done  = at_end;
  assign err        = err_q;
  assign pc         = pc_q;
  assign stalled    = exec & ~adv;
endmodule

// File: rtl/lsched_chk.sv
module lsched_chk #(
  parameter int unsigned N_TASKS = 8,
  parameter int unsigned N_PEERS = 4,
  parameter int unsigned AW      = 4,
  parameter int unsigned CNT_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     iter_done,
  input logic                     err,
  input logic                     stalled,
  input logic [AW:0]              pc,
  input logic [AW:0]              len_q,
  input logic [N_TASKS-1:0]       task_start,
  input logic [N_PEERS-1:0]       sync_out,
  input logic [N_PEERS-1:0]       sync_in,
  input logic [N_PEERS*CNT_W-1:0] cnt_all
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (task_start == '0 && sync_out == '0));
  assert_pc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pc <= len_q));
  assert_fire_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(task_start));
  assert_fire_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|task_start) |=> (pc == $past(pc) + (AW+1)'(1)));
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> $stable(pc));
  assert_post_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sync_out));
  assert_end_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done |=> !busy);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  for (genvar p = 0; p < N_PEERS; p++) begin : g_sat
    assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_all[p*CNT_W +: CNT_W] == CMAX && sync_in[p])
        |=> (cnt_all[p*CNT_W +: CNT_W] >= CMAX - 1'b1));
  end
endmodule

bind dist_local_sequencer lsched_chk #(
  .N_TASKS(N_TASKS), .N_PEERS(N_PEERS), .AW(AW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .iter_done(iter_done), .err(err),
  .stalled(stalled), .pc(pc), .len_q(len_q), .task_start(task_start),
  .sync_out(sync_out), .sync_in(sync_in), .cnt_all(cnt_all)
);

// File: tb/sim_dist_local_sequencer.sv
module sim_dist_local_sequencer;
  localparam int NT = 8, NP = 4, DEP = 16, CMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, go = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [4:0] ld_data = '0, prog_len = '0;
  logic [NT-1:0] task_done = '0, task_start;
  logic [NP-1:0] sync_in = '0, sync_out;
  logic busy, iter_done, err, stalled;
  logic [4:0] pc;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dist_local_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .go(go), .prog_len(prog_len), .task_start(task_start), .task_done(task_done),
    .sync_out(sync_out), .sync_in(sync_in), .busy(busy), .iter_done(iter_done),
    .err(err), .pc(pc), .stalled(stalled)
  );

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference, compared on every falling edge
  int m_mem[DEP];
  int m_cnt[NP];
  bit m_started[NT], m_pend[NT];
  bit m_busy, m_err;
  int m_pc, m_len;

  initial forever begin
    @(negedge clk);
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_pc = 0; m_len = 0;
      foreach (m_cnt[p]) m_cnt[p] = 0;
      foreach (m_started[i]) begin m_started[i] = 0; m_pend[i] = 0; end
    end else begin
      int e_start, e_sync, e_end, e_stall, adv, ct, cp, k, ix;
      e_start = 0; e_sync = 0; e_end = 0; e_stall = 0; adv = 0; ct = -1; cp = -1;
      if (m_busy && m_pc == m_len) e_end = 1;
      else if (m_busy) begin
        k = m_mem[m_pc] / 8; ix = m_mem[m_pc] % 8;
        if (k == 0) begin e_start = 1 << ix; adv = 1; end
        else if (k == 1) begin
          if (m_pend[ix] || (task_done[ix] && m_started[ix])) begin adv = 1; ct = ix; end
        end else if (k == 2) begin e_sync = 1 << (ix % NP); adv = 1; end
        else if (m_cnt[ix % NP] > 0 || sync_in[ix % NP]) begin adv = 1; cp = ix % NP; end
        e_stall = !adv;
      end
      cmp("R3 task_start", int'(task_start), e_start);
      cmp("R5 sync_out", int'(sync_out), e_sync);
      cmp("R2 busy", int'(busy), int'(m_busy));
      cmp("R2 pc", int'(pc), m_pc);
      cmp("R8 iter_done", int'(iter_done), e_end);
      cmp("R4 stalled", int'(stalled), e_stall);
      cmp("R9 err", int'(err), int'(m_err));
      for (int i = 0; i < NT; i++) begin
        if (task_done[i] && !m_started[i]) m_err = 1;
        m_pend[i] = (m_pend[i] || (task_done[i] && m_started[i])) && (i != ct);
        if (e_start[i]) m_started[i] = 1;
      end
      for (int p = 0; p < NP; p++) begin
        if (sync_in[p] && p != cp) m_cnt[p] = (m_cnt[p] < CMAX) ? m_cnt[p] + 1 : CMAX;
        else if (!sync_in[p] && p == cp) m_cnt[p]--;
      end
      if (ld_en && !m_busy) m_mem[ld_addr] = ld_data;
      if (!m_busy && go) begin
        m_busy = 1; m_pc = 0; m_len = prog_len;
        foreach (m_started[i]) begin m_started[i] = 0; m_pend[i] = 0; end
      end else if (e_end) m_busy = 0;
      else if (adv) m_pc++;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    task_done = '0; sync_in = '0; go = 1'b0; ld_en = 1'b0;
  endtask

  task automatic wr(int a, logic [4:0] d);
    ld_en = 1'b1; ld_addr = 4'(a); ld_data = d; cyc();
  endtask

  task automatic probe(); #2; endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    report();
  end

  initial begin
    #1;
    repeat (3) cyc();
    probe();
    cmp("R1 busy", int'(busy), 0); cmp("R1 err", int'(err), 0);
    cmp("R1 pc", int'(pc), 0); cmp("R1 task_start", int'(task_start), 0);
    rst_n = 1'b1; cyc();

    // program A: fire t2, post idx5 (peer1), join t2, await p3, fire t5, join t5
    wr(0, 5'b00010); wr(1, 5'b10101); wr(2, 5'b01010);
    wr(3, 5'b11011); wr(4, 5'b00101); wr(5, 5'b01101);
    go = 1'b1; prog_len = 5'd6; cyc();
    sync_in[3] = 1'b1; probe();
    cmp("R3 fire t2", int'(task_start), 8'h04);
    cyc();
    go = 1'b1; prog_len = 5'd1; ld_en = 1'b1; ld_addr = 4'd0; ld_data = 5'b00111;
    probe(); cmp("R5 post mod peer", int'(sync_out), 4'b0010);
    cyc();
    repeat (3) cyc();
    probe(); cmp("R4 stalled", int'(stalled), 1); cmp("R4 pc hold", int'(pc), 2);
    task_done[2] = 1'b1; cyc();
    probe(); cmp("R6 early token", int'(stalled), 0);
    cyc();
    probe(); cmp("R3 fire t5", int'(task_start), 8'h20);
    cyc();
    task_done[5] = 1'b1; cyc();
    probe(); cmp("R8 iter_done", int'(iter_done), 1); cmp("R2 len kept", int'(pc), 6);
    cyc();
    probe(); cmp("R8 busy drop", int'(busy), 0);

    go = 1'b1; prog_len = 5'd1; cyc();
    probe(); cmp("R10 entry0 unchanged", int'(task_start), 8'h04);
    cyc(); cyc();

    // early finish kept pending
    wr(0, 5'b00000); wr(1, 5'b00001); wr(2, 5'b01001); wr(3, 5'b01000);
    go = 1'b1; prog_len = 5'd4; cyc();
    cyc();
    task_done[0] = 1'b1; cyc();
    task_done[1] = 1'b1; cyc();
    probe(); cmp("R4 pending finish", int'(stalled), 0); cmp("R4 pc", int'(pc), 3);
    cyc(); cyc(); cyc();

    // zero length
    go = 1'b1; prog_len = 5'd0; cyc();
    probe(); cmp("R8 zero len", int'(iter_done), 1);
    cyc(); probe(); cmp("R8 zero len idle", int'(busy), 0);

    // saturation: 17 arrivals, 16 waits
    for (int i = 0; i < 17; i++) begin sync_in[1] = 1'b1; cyc(); end
    for (int a = 0; a < DEP; a++) wr(a, 5'b11001);
    go = 1'b1; prog_len = 5'd16; cyc();
    repeat (20) cyc();
    probe(); cmp("R7 sat pc", int'(pc), 15); cmp("R7 sat stall", int'(stalled), 1);
    sync_in[1] = 1'b1; cyc();
    probe(); cmp("R7 last token", int'(iter_done), 1);
    cyc(); cyc();

    // same-cycle token
    wr(0, 5'b11010);
    go = 1'b1; prog_len = 5'd1; cyc();
    cyc(); probe(); cmp("R6 wait", int'(stalled), 1);
    sync_in[2] = 1'b1; probe(); cmp("R6 same cycle", int'(stalled), 0);
    cyc(); probe(); cmp("R6 done", int'(iter_done), 1);
    cyc();

    // finish from an unfired task
    probe(); cmp("R9 clean", int'(err), 0);
    task_done[7] = 1'b1; cyc();
    probe(); cmp("R9 raised", int'(err), 1);
    cyc(); cyc(); probe(); cmp("R9 sticky", int'(err), 1);
    report();
  end
endmodule